// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps the time of day and the calendar in packed BCD: hundredths of a second, seconds, minutes, 24-hour hours, day of week, date, month, two-digit year and a two-bit century. A single-cycle enable strobe at the 32.768 kHz time-base rate drives it. A fractional accumulator turns those strobes into a hundredths tick whose long-term rate is exact, and a carry chain ripples that tick up through every field. Month length follows the month, and February takes a leap day whenever the year is a multiple of four.

A host bus sees eight byte registers at addresses 0 to 7. Reads come from a user copy of the counters, not from the counters themselves. The user copy follows the counters on every clock, except while the host is addressing a clock register. While that lasts, the copy is held so that a multi-byte read cannot straddle a carry. The hold lifts when the host signals a bus STOP or moves its pointer to an address of 8 or above. A host write goes straight into the running counters. Each write clears the hundredths and restarts the fractional divider.

Top module: `bcd_timekeeper`

## Requirements
- R1: After reset, all counters and the user copy are hundredths 00, seconds 00, minutes 00, hours 00, century 0, day of week 1, date 01, month 01 and year 00.
- R2: Register map, all BCD: 0 hundredths; 1 seconds; 2 minutes; 3 century in bits 7:6 (binary 0 to 3) with hours in bits 5:0; 4 day of week in bits 2:0 with zeros above; 5 date; 6 month; 7 year. Any address of 8 or more reads 00.
- R3: The hundredths tick fires only after a strobe. Each strobe adds DIV_STEP to an accumulator modulo DIV_MOD, and the tick fires when that sum wraps. With the defaults, 32768 strobes therefore give exactly 100 hundredths, and cycles without a strobe advance nothing.
- R4: Hundredths roll 99 to 00, seconds and minutes roll 59 to 00, and hours roll 23 to 00. Each roll carries one into the next field.
- R5: The day of week counts 1 to 7, returns from 7 to 1, and steps once per day rollover.
- R6: The day after the last date of a month is date 01 of the next month. Months 04, 06, 09 and 11 have 30 days, February is covered by R7, and all other months have 31.
- R7: February has 29 days when the year is divisible by four (00, 04, ... 96) and 28 days otherwise.
- R8: After Dec 31, the year advances and the date and month become 01. Year 99 goes to 00 and increments the century, and century 3 wraps to 0.
- R9: While the host addresses 0 to 7, the user copy stops following the counters. It resumes after a STOP pulse or after an access with an address of 8 or more.
- R10: A host write to address 1 to 7 loads that field of the running counters. Any clock-register write, including address 0, sets the hundredths to 00 and restarts the divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_32k | input | 1 | One-cycle strobe at the 32.768 kHz time-base rate |
| host_act | input | 1 | Host access in progress at host_addr |
| host_addr | input | ADDR_W | Host register pointer |
| host_wr | input | 1 | One-cycle write strobe for host_wdata |
| host_wdata | input | 8 | Write data |
| host_stop | input | 1 | One-cycle pulse marking a bus STOP |
| host_rdata | output | 8 | Read data from the user copy |

## Verification
A strobe is registered into the hundredths tick on the edge where it is seen. The counters move one edge later, and the user copy follows on the next edge. A result is therefore readable three edges after its strobe, and a write is readable one edge after the STOP that ends the hold. Read data is combinational from the user copy. The bench therefore allows four idle cycles after the last strobe or STOP before it samples, and it samples on falling edges. Every strobe is a single high cycle followed by a low one, so the expected hundredths are half the strobe count in the bench configuration (DIV_MOD 200, DIV_STEP 100). Each rollover result is then due after a known number of strobes.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic [1:0] cent;
    logic [7:0] year;
    logic [7:0] month;
    logic [7:0] date;
    logic [2:0] dow;
    logic [7:0] hour;
    logic [7:0] min;
    logic [7:0] sec;
    logic [7:0] hund;
  } rtc_time_t;

  localparam int unsigned NUM_REGS = 8;

  localparam rtc_time_t RTC_RESET = '{
    cent: 2'd0, year: 8'h00, month: 8'h01, date: 8'h01,
    dow: 3'd1, hour: 8'h00, min: 8'h00, sec: 8'h00, hund: 8'h00
  };

  // Increment a two-digit packed BCD value (no wrap handling).
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // 10 is 2 mod 4, so the year mod 4 is (2*tens + ones) mod 4.
  function automatic logic leap_year(input logic [7:0] y);
    logic [1:0] r;
    r = {y[4], 1'b0} + y[1:0];
    return (r == 2'd0);
  endfunction

  function automatic logic [7:0] last_date(input logic [7:0] m, input logic [7:0] y);
    case (m)
      8'h02:                      return leap_year(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  // Host-visible byte image; byte n sits at bits [8n+7:8n].
  function automatic logic [8*NUM_REGS-1:0] to_image(input rtc_time_t t);
    return {t.year, t.month, t.date, {5'd0, t.dow},
            {t.cent, t.hour[5:0]}, t.min, t.sec, t.hund};
  endfunction

endpackage

// File: rtl/rtc_rst_sync.sv
module rtc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/rtc_frac_div.sv
module rtc_frac_div #(
  parameter int unsigned DIV_MOD  = 32768,
  parameter int unsigned DIV_STEP = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic restart,
  output logic tick
);
  localparam int unsigned ACC_W = $clog2(DIV_MOD) + 1;

  logic [ACC_W-1:0] acc_q, acc_d;
  logic             tick_d;
  logic [ACC_W:0]   sum;

  always_comb begin
    sum    = {1'b0, acc_q} + (ACC_W+1)'(DIV_STEP);
    acc_d  = acc_q;
    tick_d = 1'b0;
    if (restart) begin
      acc_d = '0;
    end else if (strobe) begin
      if (sum >= (ACC_W+1)'(DIV_MOD)) begin
        acc_d  = ACC_W'(sum - (ACC_W+1)'(DIV_MOD));
        tick_d = 1'b1;
      end else begin
        acc_d  = ACC_W'(sum);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      tick  <= 1'b0;
    end else begin
      acc_q <= acc_d;
      tick  <= tick_d;
    end
  end
endmodule

// File: rtl/rtc_count_chain.sv
module rtc_count_chain
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       load,
  input  logic [2:0] load_sel,
  input  logic [7:0] load_data,
  output rtc_time_t  now
);
  rtc_time_t cur_q, nxt;
  logic c_sec, c_min, c_hour, c_day, c_month, c_year;
  logic [7:0] dim;

  always_comb begin
    nxt     = cur_q;
    c_sec   = 1'b0;
    c_min   = 1'b0;
    c_hour  = 1'b0;
    c_day   = 1'b0;
    c_month = 1'b0;
    c_year  = 1'b0;
    dim     = last_date(cur_q.month, cur_q.year);
    if (load) begin
      case (load_sel)
        3'd1: nxt.sec   = load_data & 8'h7F;
        3'd2: nxt.min   = load_data & 8'h7F;
        3'd3: begin
          nxt.cent = load_data[7:6];
          nxt.hour = {2'b00, load_data[5:0]};
        end
        3'd4: nxt.dow   = load_data[2:0];
        3'd5: nxt.date  = load_data & 8'h3F;
        3'd6: nxt.month = load_data & 8'h1F;
        3'd7: nxt.year  = load_data;
        default: ;
      endcase
      nxt.hund = 8'h00;
    end else if (tick) begin
      if (cur_q.hund == 8'h99) begin
        nxt.hund = 8'h00;
        c_sec    = 1'b1;
      end else begin
        nxt.hund = bcd_inc(cur_q.hund);
      end
      if (c_sec) begin
        if (cur_q.sec >= 8'h59) begin nxt.sec = 8'h00; c_min = 1'b1; end
        else nxt.sec = bcd_inc(cur_q.sec);
      end
      if (c_min) begin
        if (cur_q.min >= 8'h59) begin nxt.min = 8'h00; c_hour = 1'b1; end
        else nxt.min = bcd_inc(cur_q.min);
      end
      if (c_hour) begin
        if (cur_q.hour >= 8'h23) begin nxt.hour = 8'h00; c_day = 1'b1; end
        else nxt.hour = bcd_inc(cur_q.hour);
      end
      if (c_day) begin
        nxt.dow = (cur_q.dow >= 3'd7) ? 3'd1 : cur_q.dow + 3'd1;
        if (cur_q.date >= dim) begin nxt.date = 8'h01; c_month = 1'b1; end
        else nxt.date = bcd_inc(cur_q.date);
      end
      if (c_month) begin
        if (cur_q.month >= 8'h12) begin nxt.month = 8'h01; c_year = 1'b1; end
        else nxt.month = bcd_inc(cur_q.month);
      end
      if (c_year) begin
        if (cur_q.year == 8'h99) begin
          nxt.year = 8'h00;
          nxt.cent = cur_q.cent + 2'd1;
        end else begin
          nxt.year = bcd_inc(cur_q.year);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= RTC_RESET;
    else        cur_q <= nxt;
  end

  assign now = cur_q;
endmodule

// File: rtl/rtc_user_copy.sv
module rtc_user_copy
  import rtc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [8*NUM_REGS-1:0] live_img,
  input  logic                  host_act,
  input  logic                  clk_addr,
  input  logic [2:0]            reg_sel,
  input  logic                  host_stop,
  output logic [8*NUM_REGS-1:0] user_img,
  output logic                  frozen,
  output logic [7:0]            rdata
);
  logic frozen_d;
  logic copy_en;
  logic [7:0] byte_sel [NUM_REGS];

  always_comb begin
    frozen_d = frozen;
    if (host_stop)                 frozen_d = 1'b0;
    else if (host_act && !clk_addr) frozen_d = 1'b0;
    else if (host_act && clk_addr)  frozen_d = 1'b1;
  end

  assign copy_en = !frozen && !(host_act && clk_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frozen   <= 1'b0;
      user_img <= to_image(RTC_RESET);
    end else begin
      frozen <= frozen_d;
      if (copy_en) user_img <= live_img;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_bytes
    assign byte_sel[g] = user_img[8*g +: 8];
  end

  assign rdata = clk_addr ? byte_sel[reg_sel] : 8'h00;
endmodule

// File: rtl/bcd_timekeeper.sv
module bcd_timekeeper
  import rtc_pkg::*;
#(
  parameter int unsigned DIV_MOD  = 32768,
  parameter int unsigned DIV_STEP = 100,
  parameter int unsigned ADDR_W   = 6   // must be at least 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_32k,
  input  logic              host_act,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic [7:0]        host_wdata,
  input  logic              host_stop,
  output logic [7:0]        host_rdata
);
  localparam logic [ADDR_W-1:0] CLK_LIMIT = ADDR_W'(NUM_REGS);

  logic                  rst_sync_n;
  logic                  hund_pulse;
  logic                  clk_addr;
  logic                  wr_load;
  rtc_time_t             live;
  logic [8*NUM_REGS-1:0] user_img;
  logic                  frozen;

  assign clk_addr = (host_addr < CLK_LIMIT);
  assign wr_load  = host_wr && clk_addr;

  rtc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  rtc_frac_div #(.DIV_MOD(DIV_MOD), .DIV_STEP(DIV_STEP)) u_div (
    .clk(clk), .rst_n(rst_sync_n), .strobe(tick_32k),
    .restart(wr_load), .tick(hund_pulse)
  );

  rtc_count_chain u_chain (
    .clk(clk), .rst_n(rst_sync_n), .tick(hund_pulse), .load(wr_load),
    .load_sel(host_addr[2:0]), .load_data(host_wdata), .now(live)
  );

  rtc_user_copy u_copy (
    .clk(clk), .rst_n(rst_sync_n), .live_img(to_image(live)),
    .host_act(host_act), .clk_addr(clk_addr), .reg_sel(host_addr[2:0]),
    .host_stop(host_stop), .user_img(user_img), .frozen(frozen),
    .rdata(host_rdata)
  );
endmodule

// File: rtl/rtc_checker.sv
module rtc_checker
  import rtc_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  tick_32k,
  input logic                  hund_pulse,
  input logic                  wr_load,
  input logic                  host_stop,
  input logic                  frozen,
  input rtc_time_t             live,
  input logic [8*NUM_REGS-1:0] user_img
);
  p_tick_after_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hund_pulse |-> $past(tick_32k));

  p_write_zeroes_hund_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_load |=> (live.hund == 8'h00));

  p_hold_keeps_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |=> $stable(user_img));

  p_stop_releases_r9: assert property (@(posedge clk) disable iff (!rst_n)
    host_stop |=> !frozen);

  p_hour_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hund_pulse && live.hour <= 8'h23) |=> (live.hour <= 8'h23));

  p_dow_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hund_pulse && live.dow != 3'd0) |=> (live.dow != 3'd0));

  p_date_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hund_pulse && live.date != 8'h00) |=> (live.date != 8'h00));
endmodule

bind bcd_timekeeper rtc_checker u_chk (
  .clk(clk), .rst_n(rst_sync_n), .tick_32k(tick_32k), .hund_pulse(hund_pulse),
  .wr_load(wr_load), .host_stop(host_stop), .frozen(frozen),
  .live(live), .user_img(user_img)
);

// File: tb/bcd_timekeeper_tb.sv
module bcd_timekeeper_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_32k = 1'b0;
  logic       host_act = 1'b0;
  logic [5:0] host_addr = '0;
  logic       host_wr = 1'b0;
  logic [7:0] host_wdata = '0;
  logic       host_stop = 1'b0;
  logic [7:0] host_rdata;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] rb [8];

  always #5 clk = ~clk;

  bcd_timekeeper #(.DIV_MOD(200), .DIV_STEP(100), .ADDR_W(6)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .host_act(host_act),
    .host_addr(host_addr), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_stop(host_stop), .host_rdata(host_rdata)
  );

  function automatic logic [7:0] bcd(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic int mdays(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobes(input int n);
    repeat (n) begin
      @(negedge clk) tick_32k = 1'b1;
      @(negedge clk) tick_32k = 1'b0;
    end
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk);
    host_act  = 1'b1;
    host_addr = 6'(a);
    #1 d = host_rdata;
  endtask

  task automatic stop_bus();
    @(negedge clk);
    host_act  = 1'b0;
    host_stop = 1'b1;
    @(negedge clk) host_stop = 1'b0;
  endtask

  task automatic read_all();
    for (int i = 0; i < 8; i++) rd(i, rb[i]);
    stop_bus();
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    host_act = 1'b1; host_wr = 1'b1; host_addr = 6'(a); host_wdata = d;
    @(negedge clk) host_wr = 1'b0;
  endtask

  task automatic set_time(input int c, input int y, input int mo, input int dt,
                          input int dw, input int h, input int mi, input int s);
    wr(1, bcd(s));
    wr(2, bcd(mi));
    wr(3, {2'(c), bcd(h)[5:0]});
    wr(4, 8'(dw));
    wr(5, bcd(dt));
    wr(6, bcd(mo));
    wr(7, bcd(y));
    stop_bus();
    idle(3);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset values, R2 byte layout and out-of-range address
    read_all();
    chk("R1 hund", rb[0], 8'h00); chk("R1 sec", rb[1], 8'h00);
    chk("R1 min", rb[2], 8'h00);  chk("R1 cent/hour", rb[3], 8'h00);
    chk("R1 dow", rb[4], 8'h01);  chk("R1 date", rb[5], 8'h01);
    chk("R1 month", rb[6], 8'h01); chk("R1 year", rb[7], 8'h00);
    rd(9, rb[0]); chk("R2 addr9 reads zero", rb[0], 8'h00);
    stop_bus();

    // R10 write readback, R2 packing of century with hours
    set_time(2, 57, 9, 14, 5, 17, 42, 33);
    read_all();
    chk("R10 sec", rb[1], 8'h33); chk("R10 min", rb[2], 8'h42);
    chk("R2 cent/hour", rb[3], 8'h97); chk("R10 dow", rb[4], 8'h05);
    chk("R10 date", rb[5], 8'h14); chk("R10 month", rb[6], 8'h09);
    chk("R10 year", rb[7], 8'h57); chk("R10 hund cleared", rb[0], 8'h00);

    // R3 rate: 37 strobes -> 18 hundredths; idle cycles add nothing
    strobes(37); idle(4);
    rd(0, rb[0]); stop_bus(); chk("R3 hund after 37", rb[0], 8'h18);
    idle(60);
    rd(0, rb[0]); stop_bus(); chk("R3 idle no advance", rb[0], 8'h18);
    // R10 write to address 0 clears hundredths
    wr(0, 8'h77); stop_bus(); idle(3);
    rd(0, rb[0]); stop_bus(); chk("R10 addr0 clears hund", rb[0], 8'h00);

    // R4 minute carry into hour without day change
    set_time(1, 10, 6, 15, 3, 10, 59, 59);
    strobes(199); idle(4);
    rd(0, rb[0]); rd(1, rb[1]); stop_bus();
    chk("R4 hund 99", rb[0], 8'h99); chk("R4 sec 59", rb[1], 8'h59);
    strobes(1); idle(4);
    read_all();
    chk("R4 hund roll", rb[0], 8'h00); chk("R4 sec roll", rb[1], 8'h00);
    chk("R4 min roll", rb[2], 8'h00); chk("R4 hour carry", rb[3], 8'h51);
    chk("R5 dow unchanged", rb[4], 8'h03);

    // R8 Dec 31 23:59:59.99 rollover with century increment
    set_time(1, 99, 12, 31, 7, 23, 59, 59);
    strobes(200); idle(4);
    read_all();
    chk("R8 hour/cent", rb[3], 8'h80); chk("R5 dow wrap", rb[4], 8'h01);
    chk("R8 date", rb[5], 8'h01); chk("R8 month", rb[6], 8'h01);
    chk("R8 year", rb[7], 8'h00);
    // R8 century wrap 3 -> 0
    set_time(3, 99, 12, 31, 2, 23, 59, 59);
    strobes(200); idle(4);
    read_all();
    chk("R8 cent wrap", rb[3], 8'h00); chk("R8 year wrap", rb[7], 8'h00);

    // R6/R7 sweep: last day of every month, leap year 04 and common year 03
    for (int y = 3; y <= 4; y++) begin
      for (int m = 1; m <= 12; m++) begin
        int d, dw, nm, ny;
        d  = mdays(m, y);
        dw = (m % 7) + 1;
        nm = (m == 12) ? 1 : m + 1;
        ny = (m == 12) ? y + 1 : y;
        set_time(0, y, m, d, dw, 23, 59, 59);
        strobes(200); idle(4);
        read_all();
        chk((m == 2) ? "R7 feb rollover date" : "R6 month-end date", rb[5], 8'h01);
        chk((m == 2) ? "R7 feb rollover month" : "R6 month-end month", rb[6], bcd(nm));
        chk("R8 year after month end", rb[7], bcd(ny));
        chk("R5 dow step", rb[4], 8'((dw == 7) ? 1 : dw + 1));
      end
    end
    // R7 explicit: Feb 28 -> 29 in year 04, Feb 28 -> Mar 1 in year 03
    set_time(0, 4, 2, 28, 1, 23, 59, 59);
    strobes(200); idle(4); read_all();
    chk("R7 leap feb29 date", rb[5], 8'h29); chk("R7 leap month", rb[6], 8'h02);
    set_time(0, 3, 2, 28, 1, 23, 59, 59);
    strobes(200); idle(4); read_all();
    chk("R7 common mar1 date", rb[5], 8'h01); chk("R7 common month", rb[6], 8'h03);

    // R9 hold while a clock address is accessed, release on STOP
    set_time(0, 20, 5, 5, 2, 8, 30, 5);
    rd(1, rb[1]); chk("R9 initial sec", rb[1], 8'h05);
    strobes(200); idle(4);
    rd(1, rb[1]); chk("R9 held during access", rb[1], 8'h05);
    stop_bus(); idle(3);
    rd(1, rb[1]); chk("R9 after STOP", rb[1], 8'h06);
    // R9 release by moving the pointer past the clock registers
    rd(8, rb[0]);
    strobes(200); idle(4);
    rd(1, rb[1]); chk("R9 after pointer past 7", rb[1], 8'h07);
    stop_bus();

    idle(2);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule